// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is a 16-bit timer/counter with five modes. A 3-bit mode word picks the mode: plain 8-bit counting, 8-bit counting that clears on a compare match, plain 16-bit counting, or 8-bit and 16-bit counting with input capture. The counter moves up only on cycles where the tick enable picked by the clock-select field is high. A select value of zero stops it. A CPU write port can load the count at any time, and the load wins over any count or clear in the same cycle.

The block has three sticky flags: overflow, compare match and capture. Only the hardware sets them. A 3-bit clear strobe clears them, for example when an interrupt is acknowledged. The overflow flag tracks the absolute maximum of the active width, not the clear-on-compare top. So in clear-on-compare mode it fires only when the count really passes 0xFF. In the capture modes, a rising edge on the capture input copies the live count into a capture register. All logic runs on one system clock.

Top module: `mode_timer`

## Requirements
- R1: The mode word {capEn, wide, waveMode} decodes as follows:
  - 000: normal 8-bit.
  - 001: 8-bit clear-on-compare.
  - 01x: 16-bit.
  - 10x: 8-bit capture.
  - 11x: 16-bit capture.

  8-bit modes use only count[7:0]. Any increment, clear or write in an 8-bit mode leaves count[15:8] at zero.
- R2: When clkSel is 0 the count holds unless a CPU write arrives. Otherwise the count advances only in cycles where tickEn[clkSel] is high.
- R3: When cntWrEn is high, the next edge loads cntWrData into the count. In 8-bit modes only the low byte is loaded and the upper byte becomes zero. The load overrides any increment or clear in that cycle. It also stops the overflow and compare flags from being set in that cycle.
- R4: In 8-bit normal and 8-bit capture modes, the count runs up to 0xFF on ticks and then wraps to 0x00.
- R5: In both 16-bit modes the count runs up to 0xFFFF and then wraps to 0x0000.
- R6: In clear-on-compare mode, a tick while count[7:0] equals cmpVal[7:0] sends the count to 0. A new cmpVal takes effect in the same cycle it is applied.
- R7: ovfFlag is set at the same edge at which the count goes from the mode maximum to zero. The maximum is 0xFF in every 8-bit mode, including clear-on-compare, and 0xFFFF in 16-bit modes. A compare clear below 0xFF does not set it.
- R8: The flags are sticky. flagClr bit 0 clears ovfFlag, bit 1 clears cmpFlag and bit 2 clears capFlag. If a set and a clear fall in the same cycle, the set wins.
- R9: cmpFlag is set at the edge that ends a tick cycle in which the count equals cmpVal, unless a CPU write happens in that cycle. The comparison uses the low 8 bits in 8-bit modes and all 16 bits in 16-bit modes.
- R10: In the capture modes, a cycle where capIn is high after being low in the previous cycle copies that cycle's count into capVal and sets capFlag. In non-capture modes capIn has no effect.
- R11: After reset, count, capVal and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source select, 0 stops the counter |
| tickEn | input | 8 | Prescaled tick enables, indexed by clkSel |
| capEn | input | 1 | Mode bit: capture enable |
| wide | input | 1 | Mode bit: 16-bit width |
| waveMode | input | 1 | Mode bit: clear-on-compare in 8-bit non-capture mode |
| cmpVal | input | 16 | Compare register value, used without buffering |
| cntWrEn | input | 1 | CPU write strobe for the count |
| cntWrData | input | 16 | CPU write data for the count |
| capIn | input | 1 | Capture trigger |
| flagClr | input | 3 | Flag clear strobes: {cap, cmp, ovf} |
| count | output | 16 | Current count |
| capVal | output | 16 | Last captured count |
| ovfFlag | output | 1 | Overflow flag |
| cmpFlag | output | 1 | Compare-match flag |
| capFlag | output | 1 | Capture flag |

## Verification
Every result in this block is registered exactly once. The count, all three flags and capVal therefore reflect the inputs of a cycle at the first rising edge after it, with no extra pipeline stage. Capture edge detection compares against a copy of capIn registered at the previous edge.

The bench drives inputs at the falling edge and steps its reference model once per clock. It compares at the next falling edge, one full edge after the inputs were applied. Directed segments force the corner cases:
- a wrap at the maximum;
- a write at the maximum;
- a clear-on-compare count that starts above the compare value;
- a 16-bit wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MODE_NORM8,
    MODE_CTC8,
    MODE_WIDE16,
    MODE_CAP8,
    MODE_CAP16
  } tmrMode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // CPU write of the count
    logic advance;   // counting step this cycle
    logic wrapZero;  // step goes to zero instead of +1
    logic narrow;    // 8-bit width in effect
    logic setOvf;
    logic setCmp;
    logic setCap;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SEL_W-1:0]        clkSel,
  input  logic [(1<<SEL_W)-1:0]   tickEn,
  input  logic                    capEn,
  input  logic                    wide,
  input  logic                    waveMode,
  input  logic [CNT_W-1:0]        cmpVal,
  input  logic                    cntWrEn,
  input  logic                    capIn,
  input  logic [CNT_W-1:0]        count,
  output tmrStrobe_t              stb
);
  localparam int HALF = CNT_W / 2;

  tmrMode_e mode;
  logic     capInD;
  logic     tick, narrow, atMax, match, isCtc, capMode;

  always_comb begin
    case ({capEn, wide, waveMode})
      3'b000:          mode = MODE_NORM8;
      3'b001:          mode = MODE_CTC8;
      3'b010, 3'b011:  mode = MODE_WIDE16;
      3'b100, 3'b101:  mode = MODE_CAP8;
      default:         mode = MODE_CAP16;
    endcase
  end

  assign narrow  = (mode != MODE_WIDE16) && (mode != MODE_CAP16);
  assign isCtc   = (mode == MODE_CTC8);
  assign capMode = (mode == MODE_CAP8) || (mode == MODE_CAP16);
  assign tick    = (clkSel != '0) && tickEn[clkSel];
  assign atMax   = narrow ? (count[HALF-1:0] == '1) : (count == '1);
  assign match   = narrow ? (count[HALF-1:0] == cmpVal[HALF-1:0]) : (count == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN) capInD <= 1'b0;
    else       capInD <= capIn;
  end

  always_comb begin
    stb.load     = cntWrEn;
    stb.advance  = tick && !cntWrEn;
    stb.wrapZero = atMax || (isCtc && match);
    stb.narrow   = narrow;
    stb.setOvf   = tick && !cntWrEn && atMax;
    stb.setCmp   = tick && !cntWrEn && match;
    stb.setCap   = capMode && capIn && !capInD;
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [2:0]       flagClr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output logic [2:0]       flags
);
  localparam int HALF = CNT_W / 2;
  localparam logic [HALF-1:0]  ONE_H = 1;
  localparam logic [CNT_W-1:0] ONE_F = 1;

  logic [CNT_W-1:0] nextCnt;
  logic [2:0]       flagSet;

  always_comb begin
    nextCnt = count;
    if (stb.load)
      nextCnt = stb.narrow ? {{HALF{1'b0}}, cntWrData[HALF-1:0]} : cntWrData;
    else if (stb.advance) begin
      if (stb.wrapZero)     nextCnt = '0;
      else if (stb.narrow)  nextCnt = {{HALF{1'b0}}, count[HALF-1:0] + ONE_H};
      else                  nextCnt = count + ONE_F;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      capVal <= '0;
    end else begin
      count <= nextCnt;
      if (stb.setCap) capVal <= count;
    end
  end

  assign flagSet = {stb.setCap, stb.setCmp, stb.setOvf};

  for (genvar gi = 0; gi < 3; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)            flags[gi] <= 1'b0;
      else if (flagSet[gi]) flags[gi] <= 1'b1;
      else if (flagClr[gi]) flags[gi] <= 1'b0;
    end
  end

endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SEL_W-1:0]      clkSel,
  input  logic [(1<<SEL_W)-1:0] tickEn,
  input  logic                  capEn,
  input  logic                  wide,
  input  logic                  waveMode,
  input  logic [CNT_W-1:0]      cmpVal,
  input  logic                  cntWrEn,
  input  logic [CNT_W-1:0]      cntWrData,
  input  logic                  capIn,
  input  logic [2:0]            flagClr,
  output logic [CNT_W-1:0]      count,
  output logic [CNT_W-1:0]      capVal,
  output logic                  ovfFlag,
  output logic                  cmpFlag,
  output logic                  capFlag
);
  tmrStrobe_t stb;
  logic [2:0] flags;

  tmr_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .tickEn(tickEn),
    .capEn(capEn), .wide(wide), .waveMode(waveMode), .cmpVal(cmpVal),
    .cntWrEn(cntWrEn), .capIn(capIn), .count(count), .stb(stb)
  );

  tmr_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntWrData(cntWrData),
    .flagClr(flagClr), .count(count), .capVal(capVal), .flags(flags)
  );

  assign ovfFlag = flags[0];
  assign cmpFlag = flags[1];
  assign capFlag = flags[2];

endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] clkSel,
  input logic             wide,
  input logic             capEn,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic [2:0]       flagClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             cmpFlag,
  input logic             capFlag
);
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0 && !cntWrEn) |=> $stable(count));

  // R3
  wide_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && wide) |=> (count == $past(cntWrData)));

  // R7
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (count == '0));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr[0]) |=> ovfFlag);

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> !$past(cntWrEn));

  // R10
  cap_mode_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(capEn));

endmodule

bind mode_timer mode_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_mode_timer.sv
`timescale 1ns/1ps
module test_mode_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  clkSel = '0;
  logic [7:0]  tickEn = '0;
  logic        capEn = 1'b0, wide = 1'b0, waveMode = 1'b0;
  logic [15:0] cmpVal = '0;
  logic        cntWrEn = 1'b0;
  logic [15:0] cntWrData = '0;
  logic        capIn = 1'b0;
  logic [2:0]  flagClr = '0;
  logic [15:0] count, capVal;
  logic        ovfFlag, cmpFlag, capFlag;

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  logic [15:0] eCnt = '0, eCapVal = '0;
  logic        eOvf = 0, eCmp = 0, eCap = 0, eCapInD = 0;
  logic [15:0] nCnt, nCapVal;
  logic        nOvf, nCmp, nCap;
  string       cntTag;

  always #10 clk = ~clk;

  mode_timer i_mode_timer (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .tickEn(tickEn),
    .capEn(capEn), .wide(wide), .waveMode(waveMode), .cmpVal(cmpVal),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .capIn(capIn), .flagClr(flagClr),
    .count(count), .capVal(capVal), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
    .capFlag(capFlag)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, from the requirements
  task automatic modelStep();
    logic tick, narrow, ctc, atMax, match;
    tick   = (clkSel != 0) && tickEn[clkSel];
    narrow = !wide;                                   // R1
    ctc    = ({capEn, wide, waveMode} == 3'b001);
    atMax  = narrow ? (eCnt[7:0] == 8'hFF) : (eCnt == 16'hFFFF);
    match  = narrow ? (eCnt[7:0] == cmpVal[7:0]) : (eCnt == cmpVal);
    if (cntWrEn) begin
      nCnt = narrow ? {8'h00, cntWrData[7:0]} : cntWrData;  cntTag = "R3";
    end else if (tick) begin
      if (atMax || (ctc && match)) nCnt = 16'h0000;
      else if (narrow)             nCnt = {8'h00, eCnt[7:0] + 8'd1};
      else                         nCnt = eCnt + 16'd1;
      cntTag = ctc ? "R6" : (wide ? "R5/R1" : "R4/R1");
    end else begin
      nCnt = eCnt; cntTag = "R2";
    end
    nOvf = (tick && !cntWrEn && atMax) ? 1'b1 : (flagClr[0] ? 1'b0 : eOvf);
    nCmp = (tick && !cntWrEn && match) ? 1'b1 : (flagClr[1] ? 1'b0 : eCmp);
    nCap = (capEn && capIn && !eCapInD) ? 1'b1 : (flagClr[2] ? 1'b0 : eCap);
    nCapVal = (capEn && capIn && !eCapInD) ? eCnt : eCapVal;
  endtask

  task automatic runCycle();
    modelStep();
    @(negedge clk);
    eCnt = nCnt; eOvf = nOvf; eCmp = nCmp; eCap = nCap; eCapVal = nCapVal;
    eCapInD = capIn;
    check(cntTag, count, eCnt);
    check("R7/R8", {15'd0, ovfFlag}, {15'd0, eOvf});
    check("R9/R8", {15'd0, cmpFlag}, {15'd0, eCmp});
    check("R10/R8", {15'd0, capFlag}, {15'd0, eCap});
    check("R10", capVal, eCapVal);
  endtask

  task automatic setMode(input logic [2:0] m);
    {capEn, wide, waveMode} = m;
  endtask

  task automatic writeCnt(input logic [15:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    runCycle();
    cntWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", count, 16'h0);
    check("R11", capVal, 16'h0);
    check("R11", {13'd0, ovfFlag, cmpFlag, capFlag}, 16'h0);

    // normal 8-bit, wrap at FF with overflow (R4, R7)
    setMode(3'b000); clkSel = 3'd1; tickEn = 8'hFF; cmpVal = 16'h0040;
    repeat (300) runCycle();
    // stopped (R2)
    clkSel = 3'd0; flagClr = 3'b111; runCycle(); flagClr = '0;
    repeat (20) runCycle();
    // write at max with tick: write wins, no overflow (R3)
    clkSel = 3'd2; writeCnt(16'h00FF); writeCnt(16'h1234);
    repeat (5) runCycle();
    // clear-on-compare, cmp 5 (R6); then start above cmp to reach FF (R7)
    setMode(3'b001); cmpVal = 16'h0005; flagClr = 3'b111; writeCnt(16'h0000);
    flagClr = '0;
    repeat (30) runCycle();
    writeCnt(16'h00F0); repeat (40) runCycle();
    // 16-bit wrap (R5)
    setMode(3'b010); writeCnt(16'hFFFA); repeat (12) runCycle();
    // capture 8 and 16 (R10), and capture ignored in normal mode
    setMode(3'b100);
    for (int k = 0; k < 4; k++) begin
      capIn = 1'b1; runCycle(); runCycle(); capIn = 1'b0; repeat (3) runCycle();
    end
    setMode(3'b000); flagClr = 3'b100; runCycle(); flagClr = '0;
    capIn = 1'b1; runCycle(); capIn = 1'b0; runCycle();

    // constrained random
    for (int c = 0; c < 16000; c++) begin
      if (c % 256 == 0) setMode(3'($urandom));
      if (c % 64 == 0)
        cmpVal = ($urandom % 2 == 0) ? 16'($urandom % 32) : 16'($urandom);
      clkSel  = ($urandom % 8 == 0) ? 3'd0 : 3'($urandom);
      tickEn  = 8'($urandom) | 8'($urandom);
      cntWrEn = ($urandom % 32 == 0);
      case ($urandom % 3)
        0:       cntWrData = 16'hFFFC;
        1:       cntWrData = 16'h00FC;
        default: cntWrData = 16'($urandom);
      endcase
      if ($urandom % 4 == 0) capIn = ~capIn;
      flagClr = ($urandom % 16 == 0) ? 3'($urandom) : 3'b000;
      runCycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule